// File: doc/BRIEF.md
# SPI Panel Register Initialization Sequencer

This block prepares a display panel for use over an SPI link that only writes. A start pulse makes it step through a fixed table of register address/data pairs. Each pair goes out as one 32-bit frame in SPI mode 0. The last table entry turns the display on, and a timed pause always comes before it. Two short sequences act on the display-control register, which is at address 0x02. A sleep request writes 0x01 to it and then holds busy for a long settling time. A wake request writes 0x00 to it and then runs the whole table again.

A level input mirrors the display enable onto an active-high panel reset-release output. A busy level and a one-cycle done pulse let the surrounding logic tell when a sequence has ended. The pause length and the hold length are set in microseconds. They are turned into cycle counts from a clock-frequency parameter. The SPI bit rate is set by a half-period divider parameter.

Top module: `spi_panel_init`

## Requirements
- R1: Every frame is 32 bits, shifted out MSB first. Bits [31:24] are 0x00, bits [23:16] are the register address, bits [15:8] are 0x01 and bits [7:0] are the register data.
- R2: SPI mode 0 is used. spiSclk is low whenever spiCsN is high. spiMosi does not change while spiSclk is high. Each frame has exactly 32 rising edges of spiSclk while spiCsN is low.
- R3: A start request sends the 12-entry table in this order, written as (address, data) in hex: (03,01) (00,00) (01,01) (04,00) (05,14) (06,24) (10,D7) (13,55) (20,2F) (50,0C) (79,30) (02,00).
- R4: Between the end of the eleventh table frame (spiCsN rises) and the start of the final frame (spiCsN falls), at least GAP_US microseconds pass, counted as CLK_HZ/1e6*GAP_US cycles.
- R5: A sleep request sends exactly one frame, (02,01). busy then stays high for at least HOLD_US microseconds after that frame ends, counted in cycles as for R4. Only then does done pulse.
- R6: A wake request first sends one frame, (02,00). It then sends the full R3 table, including the R4 pause before the final entry.
- R7: Between two frames, spiCsN stays high for at least 2*SCLK_HALF clock cycles, which is one SCLK period.
- R8: panelResetRel is low out of reset. On each clock edge it takes the value of panelEnable, so it follows that input one cycle later.
- R9: A start, sleep or wake request that arrives while busy is high is ignored. No extra frames are sent.
- R10: busy goes high in the cycle after a request is accepted. done is high for exactly one cycle when a sequence ends, and busy is low in that same cycle.
- R11: When several requests arrive together while idle, sleep is taken first, then wake, then start. The requests that lose are dropped.
- R12: During reset, spiCsN is 1, spiSclk is 0, busy is 0, done is 0 and panelResetRel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Pulse that runs the init table |
| sleepReq | input | 1 | Pulse that puts the panel to sleep |
| wakeReq | input | 1 | Pulse that wakes the panel and runs the table again |
| panelEnable | input | 1 | Display enable level |
| spiSclk | output | 1 | SPI clock, idles low |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | SPI data to the panel |
| panelResetRel | output | 1 | Panel reset release, active high |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence finishes |

## Verification
Two kinds of collision matter here. The first is between request acceptance and requests that arrive together. The bench pulses all three requests in the same idle cycle and checks that only the single sleep frame appears. It then pulses wake and start together and checks that the captured stream begins with the wake frame. The second is between a running sequence and new requests. All three requests are pulsed in the middle of a table run. The captured word count must stay at the plain table length, and no frame may appear after done.

// File: rtl/panel_init_pkg.sv
package panel_init_pkg;

  localparam int TBL_LEN = 12;
  localparam logic [7:0] CTRL_ADDR = 8'h02;
  localparam logic [7:0] CTRL_SLEEP = 8'h01;
  localparam logic [7:0] CTRL_WAKE = 8'h00;

  // strobes from control to the frame shifter
  typedef struct packed {
    logic        load;
    logic [31:0] frame;
  } ctl_strobe_t;

  // two tagged halves: address half tagged 0x00, data half tagged 0x01
  function automatic logic [31:0] packFrame(input logic [7:0] addr, input logic [7:0] data);
    return {8'h00, addr, 8'h01, data};
  endfunction

  // returns {address, data}; the last entry is the display-on write
  function automatic logic [15:0] tblEntry(input int unsigned i);
    case (i)
      0:       return {8'h03, 8'h01};
      1:       return {8'h00, 8'h00};
      2:       return {8'h01, 8'h01};
      3:       return {8'h04, 8'h00};
      4:       return {8'h05, 8'h14};
      5:       return {8'h06, 8'h24};
      6:       return {8'h10, 8'hD7};
      7:       return {8'h13, 8'h55};
      8:       return {8'h20, 8'h2F};
      9:       return {8'h50, 8'h0C};
      10:      return {8'h79, 8'h30};
      default: return {CTRL_ADDR, CTRL_WAKE};
    endcase
  endfunction

  function automatic logic [31:0] tblFrame(input int unsigned i);
    logic [15:0] e;
    e = tblEntry(i);
    return packFrame(e[15:8], e[7:0]);
  endfunction

endpackage

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
  import panel_init_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t strobe,
  output logic        frameDone,
  output logic        sclk,
  output logic        csN,
  output logic        mosi
);
  localparam int DIV_W = $clog2(2 * SCLK_HALF + 1);
  localparam logic [DIV_W-1:0] HALF_END = DIV_W'(SCLK_HALF - 1);
  localparam logic [DIV_W-1:0] TAIL_END = DIV_W'(2 * SCLK_HALF - 1);

  logic [31:0]      shiftReg;
  logic [DIV_W-1:0] divCnt;
  logic [5:0]       bitCnt;
  logic             active;
  logic             tail;

  assign mosi = shiftReg[31];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      divCnt    <= '0;
      bitCnt    <= '0;
      active    <= 1'b0;
      tail      <= 1'b0;
      sclk      <= 1'b0;
      csN       <= 1'b1;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (!active) begin
        if (strobe.load) begin
          shiftReg <= strobe.frame;
          csN      <= 1'b0;
          active   <= 1'b1;
          divCnt   <= '0;
          bitCnt   <= '0;
          sclk     <= 1'b0;
          tail     <= 1'b0;
        end
      end else if (tail) begin
        if (divCnt == TAIL_END) begin
          active    <= 1'b0;
          tail      <= 1'b0;
          frameDone <= 1'b1;
          divCnt    <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end else if (divCnt == HALF_END) begin
        divCnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk     <= 1'b0;
          shiftReg <= {shiftReg[30:0], 1'b0};
          bitCnt   <= bitCnt + 1'b1;
          if (bitCnt == 6'd31) begin
            tail <= 1'b1;
            csN  <= 1'b1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/panel_seq_ctl.sv
module panel_seq_ctl
  import panel_init_pkg::*;
#(
  parameter int GAP_CYC  = 2500,
  parameter int HOLD_CYC = 5000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        sleepReq,
  input  logic        wakeReq,
  input  logic        frameDone,
  output ctl_strobe_t strobe,
  output logic        busy,
  output logic        done
);
  localparam int MAX_CYC = (GAP_CYC > HOLD_CYC) ? GAP_CYC : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int IDX_W   = $clog2(TBL_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TBL_LEN - 1);
  localparam logic [IDX_W-1:0] PENULT_IDX = IDX_W'(TBL_LEN - 2);
  localparam logic [CNT_W-1:0] GAP_END = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GAP, S_HOLD} state_t;
  typedef enum logic [1:0] {K_SLEEP, K_WAKE, K_TABLE} kind_t;

  state_t           state;
  kind_t            kind;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      kind   <= K_TABLE;
      idx    <= '0;
      cnt    <= '0;
      strobe <= '0;
      done   <= 1'b0;
    end else begin
      strobe.load <= 1'b0;
      done        <= 1'b0;
      case (state)
        S_IDLE: begin
          if (sleepReq) begin
            strobe <= '{load: 1'b1, frame: packFrame(CTRL_ADDR, CTRL_SLEEP)};
            kind   <= K_SLEEP;
            state  <= S_WAIT;
          end else if (wakeReq) begin
            strobe <= '{load: 1'b1, frame: packFrame(CTRL_ADDR, CTRL_WAKE)};
            kind   <= K_WAKE;
            state  <= S_WAIT;
          end else if (startReq) begin
            strobe <= '{load: 1'b1, frame: tblFrame(0)};
            kind   <= K_TABLE;
            idx    <= '0;
            state  <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (frameDone) begin
            case (kind)
              K_SLEEP: begin
                state <= S_HOLD;
                cnt   <= '0;
              end
              K_WAKE: begin
                kind   <= K_TABLE;
                idx    <= '0;
                strobe <= '{load: 1'b1, frame: tblFrame(0)};
              end
              default: begin
                if (idx == LAST_IDX) begin
                  done  <= 1'b1;
                  state <= S_IDLE;
                end else if (idx == PENULT_IDX) begin
                  state <= S_GAP;
                  cnt   <= '0;
                end else begin
                  idx    <= idx + 1'b1;
                  strobe <= '{load: 1'b1, frame: tblFrame(int'(idx) + 1)};
                end
              end
            endcase
          end
        end
        S_GAP: begin
          if (cnt == GAP_END) begin
            idx    <= LAST_IDX;
            strobe <= '{load: 1'b1, frame: tblFrame(TBL_LEN - 1)};
            state  <= S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == HOLD_END) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_panel_init.sv
module spi_panel_init
  import panel_init_pkg::*;
#(
  parameter int CLK_HZ    = 125000000,
  parameter int GAP_US    = 20,
  parameter int HOLD_US   = 40000,
  parameter int SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic sleepReq,
  input  logic wakeReq,
  input  logic panelEnable,
  output logic spiSclk,
  output logic spiCsN,
  output logic spiMosi,
  output logic panelResetRel,
  output logic busy,
  output logic done
);
  localparam int CYC_PER_US = CLK_HZ / 1000000;
  localparam int GAP_CYC    = CYC_PER_US * GAP_US;
  localparam int HOLD_CYC   = CYC_PER_US * HOLD_US;

  ctl_strobe_t strobe;
  logic        frameDone;

  panel_seq_ctl #(
    .GAP_CYC (GAP_CYC),
    .HOLD_CYC(HOLD_CYC)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .sleepReq (sleepReq),
    .wakeReq  (wakeReq),
    .frameDone(frameDone),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  spi_frame_tx #(
    .SCLK_HALF(SCLK_HALF)
  ) u_tx (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .frameDone(frameDone),
    .sclk     (spiSclk),
    .csN      (spiCsN),
    .mosi     (spiMosi)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) panelResetRel <= 1'b0;
    else       panelResetRel <= panelEnable;
  end
endmodule

// File: rtl/panel_init_chk.sv
module panel_init_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic sleepReq,
  input logic wakeReq,
  input logic panelEnable,
  input logic spiSclk,
  input logic spiCsN,
  input logic spiMosi,
  input logic panelResetRel,
  input logic busy,
  input logic done
);
  AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiSclk); // R2

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (spiSclk && $past(spiSclk)) |-> $stable(spiMosi)); // R2

  AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> busy); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy))); // R10

  AST_IDLE_REQ_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (startReq || sleepReq || wakeReq)) |=> busy); // R10

  AST_RESET_REL_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (panelResetRel == $past(panelEnable))); // R8
endmodule

bind spi_panel_init panel_init_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .startReq     (startReq),
  .sleepReq     (sleepReq),
  .wakeReq      (wakeReq),
  .panelEnable  (panelEnable),
  .spiSclk      (spiSclk),
  .spiCsN       (spiCsN),
  .spiMosi      (spiMosi),
  .panelResetRel(panelResetRel),
  .busy         (busy),
  .done         (done)
);

// File: tb/tb_spi_panel_init.sv
`timescale 1ns/1ps
module tb_spi_panel_init;
  localparam int CLK_HZ    = 1000000;
  localparam int GAP_US    = 20;
  localparam int HOLD_US   = 40000;
  localparam int SCLK_HALF = 2;
  localparam int GAP_CYC   = GAP_US;
  localparam int HOLD_CYC  = HOLD_US;
  localparam int NTBL      = 12;

  // stimulus: 0 start, 1 sleep, 2 wake; expected frame counts alongside
  localparam int NVEC = 4;
  localparam int VEC_OP  [0:NVEC-1] = '{0, 1, 2, 0};
  localparam int VEC_NFR [0:NVEC-1] = '{12, 1, 13, 12};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, sleepReq = 1'b0, wakeReq = 1'b0, panelEnable = 1'b0;
  logic spiSclk, spiCsN, spiMosi, panelResetRel, busy, done;

  spi_panel_init #(.CLK_HZ(CLK_HZ), .GAP_US(GAP_US), .HOLD_US(HOLD_US),
                   .SCLK_HALF(SCLK_HALF)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sleepReq(sleepReq),
    .wakeReq(wakeReq), .panelEnable(panelEnable), .spiSclk(spiSclk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .panelResetRel(panelResetRel),
    .busy(busy), .done(done));

  always #4 clk = ~clk;

  int nChk = 0, nFail = 0, modeErr = 0;
  longint cyc = 0;
  longint doneCyc = 0;
  logic [31:0] capWord [0:31];
  longint riseT [0:31];
  longint fallT [0:31];
  int nCap = 0, nBits = 0;
  logic [31:0] shiftIn = '0;
  logic prevSclk = 1'b0, prevMosi = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge spiSclk) begin
    shiftIn <= {shiftIn[30:0], spiMosi};
    nBits   <= nBits + 1;
  end
  always @(negedge spiCsN) begin
    nBits <= 0;
    if (nCap < 32) fallT[nCap] = cyc;
  end
  always @(posedge spiCsN) begin
    if (rstN && nCap < 32) begin
      capWord[nCap] = (nBits == 32) ? shiftIn : 32'hDEAD_BEEF;
      riseT[nCap]   = cyc;
      nCap          = nCap + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (spiCsN && spiSclk) modeErr++;
      if (spiSclk && prevSclk && spiMosi != prevMosi) modeErr++;
    end
    prevSclk <= spiSclk;
    prevMosi <= spiMosi;
  end

  function automatic logic [31:0] mk(input logic [7:0] a, input logic [7:0] d);
    return {8'h00, a, 8'h01, d};
  endfunction

  function automatic logic [31:0] benchTbl(input int k);
    case (k)
      0: return mk(8'h03, 8'h01);  1: return mk(8'h00, 8'h00);
      2: return mk(8'h01, 8'h01);  3: return mk(8'h04, 8'h00);
      4: return mk(8'h05, 8'h14);  5: return mk(8'h06, 8'h24);
      6: return mk(8'h10, 8'hD7);  7: return mk(8'h13, 8'h55);
      8: return mk(8'h20, 8'h2F);  9: return mk(8'h50, 8'h0C);
      10: return mk(8'h79, 8'h30); default: return mk(8'h02, 8'h00);
    endcase
  endfunction

  function automatic logic [31:0] expWord(input int op, input int k);
    if (op == 1) return mk(8'h02, 8'h01);
    if (op == 2) return (k == 0) ? mk(8'h02, 8'h00) : benchTbl(k - 1);
    return benchTbl(k);
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic s, input logic sl, input logic w);
    @(negedge clk);
    startReq = s; sleepReq = sl; wakeReq = w;
    @(negedge clk);
    startReq = 0; sleepReq = 0; wakeReq = 0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 60000; i++) begin
      if (done) begin
        doneCyc = cyc;
        return;
      end
      @(negedge clk);
    end
    check(0, "R10 done timeout", 0, 1);
  endtask

  // compare captured stream with an expected operation
  task automatic judge(input int op, input int nfr);
    check(nCap == nfr, "R3/R5/R6 frame count", nCap, nfr);
    for (int k = 0; k < nfr && k < nCap; k++)
      check(capWord[k] == expWord(op, k), "R1/R3 frame content", capWord[k], expWord(op, k));
    for (int k = 1; k < nCap; k++)
      check(fallT[k] - riseT[k-1] >= 2 * SCLK_HALF, "R7 cs high gap",
            fallT[k] - riseT[k-1], 2 * SCLK_HALF);
    if (op != 1 && nCap == nfr)
      check(fallT[nfr-1] - riseT[nfr-2] >= GAP_CYC, "R4 pause before final",
            fallT[nfr-1] - riseT[nfr-2], GAP_CYC);
    if (op == 1 && nCap >= 1)
      check(doneCyc - riseT[0] >= HOLD_CYC, "R5 sleep hold",
            doneCyc - riseT[0], HOLD_CYC);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 190000) begin
        nFail++;
        nChk++;
        $display("FAIL watchdog: actual %0d expected below 190000", cyc);
        summary();
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(spiCsN == 1 && spiSclk == 0 && busy == 0 && done == 0 && panelResetRel == 0,
          "R12 reset state", {spiCsN, spiSclk, busy, done, panelResetRel}, 5'b10000);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R8 reset-release follows enable
    panelEnable = 1;
    @(negedge clk);
    check(panelResetRel == 1, "R8 enable high", panelResetRel, 1);
    panelEnable = 0;
    @(negedge clk);
    check(panelResetRel == 0, "R8 enable low", panelResetRel, 0);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      nCap = 0;
      pulse(VEC_OP[v] == 0, VEC_OP[v] == 1, VEC_OP[v] == 2);
      check(busy == 1, "R10 busy after request", busy, 1);
      waitDone();
      check(busy == 0, "R10 busy low at done", busy, 0);
      @(negedge clk);
      check(done == 0, "R10 done one cycle", done, 0);
      judge(VEC_OP[v], VEC_NFR[v]);
    end

    // R9 requests during a run are ignored
    nCap = 0;
    pulse(1, 0, 0);
    repeat (300) @(negedge clk);
    pulse(1, 1, 1);
    waitDone();
    repeat (200) @(negedge clk);
    check(busy == 0, "R9 idle after run", busy, 0);
    judge(0, NTBL);

    // R11 simultaneous requests: sleep wins
    nCap = 0;
    pulse(1, 1, 1);
    waitDone();
    repeat (50) @(negedge clk);
    judge(1, 1);

    // R11 wake beats start
    nCap = 0;
    pulse(1, 0, 1);
    waitDone();
    repeat (50) @(negedge clk);
    judge(2, NTBL + 1);

    check(modeErr == 0, "R2 mode 0 timing", modeErr, 0);
    summary();
    $finish;
  end
endmodule